// File: doc/BRIEF.md
# Serial Frame Format Decoder and Fractional Baud Tick Generator

This block holds the configuration of one serial channel and produces the channel's oversampling timebase. Software writes three registers through a simple write/read port: a line control byte, an integer baud divisor and a 3-bit fractional adjustment. The block decodes the character length, the stop bit count and the parity mode from the line control byte and presents them as steady outputs that the serial shifters use. A free-running counter, clocked by the reference clock (nominally 24 MHz), emits a one-cycle tick once per baud period. The period in reference cycles is sixteen times the divisor, plus the fraction, plus sixteen.

A divisor of zero turns the generator off. The block then raises a disabled flag and sends no ticks. While the divisor is zero, new line control settings are held back: the decoded outputs keep the last format applied and take up the stored byte only once a nonzero divisor is present. Any register write restarts the period counter, so the first tick after a rate change comes a whole new period later.

Top module: `serial_fmt_baudgen`

## Requirements
- R1: After reset all three registers read zero, `baud_off` is 1, `os_tick` is 0, and the decoded format is 5 data bits, one stop bit and no parity.
- R2: `data_bits` equals line control bits [1:0] plus five, giving the range 5 to 8.
- R3: `two_stop` is 1 exactly when line control bit 2 is set.
- R4: `parity_on` follows line control bit 5. `parity_even` is 1 when bits 5 and 3 are both set. Bit 5 set with bit 3 clear means odd parity.
- R5: With a nonzero divisor D and fraction F, `os_tick` is a one-cycle pulse repeating every 16*D + F + 16 clock cycles.
- R6: A write to any register restarts the counter. The first tick falls exactly one full period (16*D + F + 16 cycles) after the cycle in which the write is sampled.
- R7: When the divisor is zero, `baud_off` is 1 and `os_tick` stays 0. When the divisor is nonzero, `baud_off` is 0.
- R8: The decoded format outputs copy the stored line control byte one cycle after it is stored, but only while the divisor is nonzero. While the divisor is zero they hold their value.
- R9: Register addresses are 0 for line control (8 bits), 1 for the divisor (16 bits) and 2 for the fraction (3 bits). `reg_rdata` returns the selected register zero-extended, and address 3 reads zero. Written bits beyond a register's width are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | DIV_W (16) | Write data |
| reg_rdata | output | DIV_W (16) | Read data of the selected register |
| data_bits | output | 4 | Character length, 5 to 8 |
| two_stop | output | 1 | Two stop bits selected |
| parity_on | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity selected |
| baud_off | output | 1 | Generator disabled, divisor is zero |
| os_tick | output | 1 | One-cycle oversampling tick |

## Verification
The bench builds the block with its default widths: a 16-bit divisor, a 3-bit fraction and an 8-bit line control byte. With these widths all 256 line control values and every fraction from 0 to 7 can be tested. Random divisors are kept below about forty so that many period measurements fit in the cycle budget. Directed cases cover divisor 1 with fractions 0 and 7, which is the shortest period, and the hand-over of a held format when the divisor returns from zero.

// File: rtl/serial_fmt_baudgen.sv
module serial_fmt_baudgen #(
  parameter int DIV_W  = 16,
  parameter int FRAC_W = 3,
  parameter int LCW_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [DIV_W-1:0] reg_wdata,
  output logic [DIV_W-1:0] reg_rdata,
  output logic [3:0]       data_bits,
  output logic             two_stop,
  output logic             parity_on,
  output logic             parity_even,
  output logic             baud_off,
  output logic             os_tick
);
  localparam int PER_W = DIV_W + 5;

  logic [LCW_W-1:0]  lcw_q;
  logic [DIV_W-1:0]  div_q;
  logic [FRAC_W-1:0] frac_q;
  logic [4:0]        fmt_q;
  logic [PER_W-1:0]  period, cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcw_q  <= '0;
      div_q  <= '0;
      frac_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        2'd0:    lcw_q  <= reg_wdata[LCW_W-1:0];
        2'd1:    div_q  <= reg_wdata;
        2'd2:    frac_q <= reg_wdata[FRAC_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = DIV_W'(lcw_q);
      2'd1:    reg_rdata = div_q;
      2'd2:    reg_rdata = DIV_W'(frac_q);
      default: reg_rdata = '0;
    endcase
  end

  assign baud_off = (div_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fmt_q <= '0;
    else if (!baud_off) fmt_q <= {lcw_q[5], lcw_q[5] & lcw_q[3], lcw_q[2], lcw_q[1:0]};
  end

  assign data_bits   = 4'd5 + {2'b00, fmt_q[1:0]};
  assign two_stop    = fmt_q[2];
  assign parity_even = fmt_q[3];
  assign parity_on   = fmt_q[4];

  assign period = {1'b0, div_q, 4'b0000} + PER_W'(frac_q) + PER_W'(16);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (reg_wr || baud_off)  cnt <= '0;
    else if (cnt == period - 1'b1) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign os_tick = !baud_off && (cnt == period - 1'b1);

  // R5
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    os_tick |=> !os_tick);
  // R5
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < period);
  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !os_tick);
  // R7
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_off |-> !os_tick);
  // R8
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_off |=> $stable({data_bits, two_stop, parity_on, parity_even}));
endmodule

// File: tb/sim_serial_fmt_baudgen.sv
`timescale 1ns/1ps
module sim_serial_fmt_baudgen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [3:0]  data_bits;
  logic        two_stop, parity_on, parity_even, baud_off, os_tick;
  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  serial_fmt_baudgen u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .data_bits(data_bits),
    .two_stop(two_stop), .parity_on(parity_on), .parity_even(parity_even),
    .baud_off(baud_off), .os_tick(os_tick));

  function automatic int exp_period(int d, int f);
    return 16 * d + f + 16;
  endfunction

  function automatic logic [6:0] exp_fmt(logic [7:0] l);
    return {4'(l[1:0]) + 4'd5, l[2], l[5], l[5] & l[3]};
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic measure(int d, int f);
    int p = exp_period(d, f);
    int k = 1;
    wr(2'd2, 16'(f));
    wr(2'd1, 16'(d));
    while (!os_tick && k < p + 8) begin
      @(negedge clk);
      k++;
    end
    chk("R6 first tick", k, p);
    for (int n = 0; n < 2; n++) begin
      int m = 0;
      do begin
        @(negedge clk);
        m++;
        if (m == 1) chk("R5 one-cycle pulse", os_tick, 0);
      end while (!os_tick && m < p + 8);
      chk("R5 period", m, p);
    end
  endtask

  task automatic fmt_check(logic [7:0] l, string req);
    logic [6:0] e = exp_fmt(l);
    chk({req, " R2 data_bits"}, data_bits, e[6:3]);
    chk({req, " R3 two_stop"}, two_stop, e[2]);
    chk({req, " R4 parity_on"}, parity_on, e[1]);
    chk({req, " R4 parity_even"}, parity_even, e[0]);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
    $finish;
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 lcw", v, 0);
    rd(2'd1, v); chk("R1 div", v, 0);
    rd(2'd2, v); chk("R1 frac", v, 0);
    chk("R1 baud_off", baud_off, 1);
    chk("R1 os_tick", os_tick, 0);
    fmt_check(8'h00, "R1");

    measure(1, 0);
    measure(1, 7);
    measure(3, 7);
    for (int i = 0; i < 6; i++)
      measure(int'($urandom_range(40, 1)), int'($urandom_range(7, 0)));

    chk("R7 baud_off low", baud_off, 0);
    for (int i = 0; i < 12; i++) begin
      logic [7:0] l = 8'($urandom);
      wr(2'd0, {8'($urandom), l});
      @(negedge clk);
      fmt_check(l, "R8 applied");
      rd(2'd0, v); chk("R9 lcw readback", v, {8'h00, l});
    end
    wr(2'd0, 16'h0024); @(negedge clk); fmt_check(8'h24, "R4 odd");
    wr(2'd0, 16'h002F); @(negedge clk); fmt_check(8'h2F, "R4 even");

    wr(2'd1, 16'd0);
    chk("R7 baud_off set", baud_off, 1);
    begin
      int seen = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (os_tick) seen++;
      end
      chk("R7 no tick when off", seen, 0);
    end
    wr(2'd0, 16'h0009);
    @(negedge clk); @(negedge clk);
    fmt_check(8'h2F, "R8 held");
    rd(2'd0, v); chk("R9 lcw stored while off", v, 16'h0009);
    wr(2'd1, 16'd5);
    @(negedge clk);
    fmt_check(8'h09, "R8 released");

    wr(2'd2, 16'hFFFF); rd(2'd2, v); chk("R9 frac width", v, 7);
    wr(2'd0, 16'hABCD); rd(2'd0, v); chk("R9 lcw width", v, 16'h00CD);
    rd(2'd1, v); chk("R9 div readback", v, 5);
    wr(2'd3, 16'h1234); rd(2'd3, v); chk("R9 addr3 zero", v, 0);
    measure(2, 5);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule